// File: doc/BRIEF.md
# Sample-Fetch Bus-Steal Controller

This block services one-byte fetch requests from an audio sample channel by taking cycles away from the CPU. When a request arrives, the block looks at what the CPU bus is doing in that same cycle and at the position of any sprite page transfer. From those it picks a stall length, holds the CPU halted for that many cycles, and reads the requested sample address once. The byte goes back to the sample channel with a one-clock valid strobe.

The bus never goes idle. Every halted cycle is a read. All halted cycles except the last present the CPU's program-counter address. The last halted cycle presents the sample address, and the byte returned on that cycle is the one kept.

Only one request can wait behind the fetch in progress. It starts directly after that fetch, with no gap. Any request that arrives while that waiting slot is occupied is discarded.

Top module: `sample_fetch_stall`

## Requirements
- R1: After reset, `halt_o` and `smp_valid_o` are low and `bus_addr_o` equals `cpu_addr_i`.
- R2: A request sampled while `cpu_rd_i`=1 (CPU read), with no trigger write and no page transfer busy, halts the CPU for exactly 4 consecutive cycles, starting the clock after the request.
- R3: A request sampled while `cpu_rd_i`=0 (CPU write), with no trigger write and no page transfer, halts the CPU for 3 cycles.
- R4: A request sampled on a trigger-write cycle (`trig_wr_i`=1) halts the CPU for 2 cycles, even when `cpu_rd_i`=0.
- R5: A request sampled while `spr_busy_i`=1 and `spr_left_i` is neither 1 nor 3 halts the CPU for 2 cycles.
- R6: A request sampled while `spr_busy_i`=1 and `spr_left_i`=3 (third-to-last transfer cycle, where `spr_left_i` counts cycles left including the current one) halts the CPU for 1 cycle.
- R7: A request sampled while `spr_busy_i`=1 and `spr_left_i`=1 (last transfer cycle) halts the CPU for 3 cycles.
- R8: During every halted cycle except the last of a fetch, `bus_addr_o` equals `cpu_pc_i`. On the last halted cycle it equals the captured sample address.
- R9: In the clock after a fetch's last halted cycle, `smp_valid_o` is high for exactly one cycle. `smp_data_o` then holds the `bus_rdata_i` value read on that last cycle.
- R10: A request sampled while a fetch still has more than one halted cycle to go waits in a one-entry slot. Its stall length is chosen from the bus state at the moment it arrives. It starts right after the current fetch, and the halt stays high between the two.
- R11: A request sampled while the waiting slot is already occupied is dropped. The total halt length and the number of valid strobes are unchanged.
- R12: When no fetch is active, `halt_o` is low and `bus_addr_o` follows `cpu_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_req_i | input | 1 | Fetch request, one cycle per request |
| smp_addr_i | input | ADDR_W | Sample address to read |
| cpu_rd_i | input | 1 | CPU bus direction in this cycle, 1 = read, 0 = write |
| trig_wr_i | input | 1 | This cycle writes the page-transfer trigger register |
| spr_busy_i | input | 1 | A sprite page transfer is running |
| spr_left_i | input | LEFT_W | Cycles left in the page transfer, current cycle included |
| cpu_pc_i | input | ADDR_W | CPU program-counter address |
| cpu_addr_i | input | ADDR_W | CPU's own bus address |
| bus_rdata_i | input | DATA_W | Read data from the bus |
| halt_o | output | 1 | CPU halt |
| bus_addr_o | output | ADDR_W | Bus address |
| smp_data_o | output | DATA_W | Fetched sample byte |
| smp_valid_o | output | 1 | One-clock strobe for `smp_data_o` |

## Verification
The bench places requests in each bus situation and counts the halted cycles. It covers both end-of-transfer positions and also the second-to-last position, where the cost falls back to 2. A design that got the ending order backwards would report 3 and 1 where 1 and 3 are expected. A design that gave a write priority over a trigger write would stall 3 cycles instead of 2. The bench checks that the sample address appears only on the final halted cycle, so a read of the sample address too early, or a program-counter read in its place, shows up as wrong returned data. It also sends a second request into the middle of a fetch and a third one behind it. That catches a controller that releases the halt between the two fetches, that prices the waiting request from the bus state at a later cycle, or that overwrites the waiting slot.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

   // Bus situation seen when a request is sampled, in decreasing priority.
   typedef enum logic [2:0] {
      SIT_XFER_LAST  = 3'd0,
      SIT_XFER_THIRD = 3'd1,
      SIT_XFER_MID   = 3'd2,
      SIT_CPU_WRITE  = 3'd3,
      SIT_CPU_READ   = 3'd4
   } bus_sit_e;

endpackage

// File: rtl/sfs_cost_sel.sv
module sfs_cost_sel
   import sfs_pkg::*;
#(
   parameter int LEFT_W      = 9,
   parameter int COST_W      = 3,
   parameter int COST_READ   = 4,
   parameter int COST_WRITE  = 3,
   parameter int COST_XFER   = 2,
   parameter int COST_THIRD  = 1,
   parameter int COST_LAST   = 3
) (
   input  logic              cpu_rd_i,
   input  logic              trig_wr_i,
   input  logic              spr_busy_i,
   input  logic [LEFT_W-1:0] spr_left_i,
   output logic [COST_W-1:0] cost_o
);

   localparam logic [LEFT_W-1:0] POS_LAST  = LEFT_W'(1);
   localparam logic [LEFT_W-1:0] POS_THIRD = LEFT_W'(3);

   bus_sit_e sit;

   always_comb begin
      if (spr_busy_i && spr_left_i == POS_LAST)
         sit = SIT_XFER_LAST;
      else if (spr_busy_i && spr_left_i == POS_THIRD)
         sit = SIT_XFER_THIRD;
      else if (spr_busy_i || trig_wr_i)
         sit = SIT_XFER_MID;
      else if (!cpu_rd_i)
         sit = SIT_CPU_WRITE;
      else
         sit = SIT_CPU_READ;
   end

   // Single place that maps a bus situation to its stall length.
   always_comb begin
      unique case (sit)
         SIT_XFER_LAST:  cost_o = COST_W'(COST_LAST);
         SIT_XFER_THIRD: cost_o = COST_W'(COST_THIRD);
         SIT_XFER_MID:   cost_o = COST_W'(COST_XFER);
         SIT_CPU_WRITE:  cost_o = COST_W'(COST_WRITE);
         default:        cost_o = COST_W'(COST_READ);
      endcase
   end

endmodule

// File: rtl/sfs_pending.sv
module sfs_pending #(
   parameter int ADDR_W  = 16,
   parameter int COST_W  = 3,
   parameter bit PEND_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [COST_W-1:0] req_cost_i,
   input  logic              load_i,
   output logic              pend_v_o,
   output logic [ADDR_W-1:0] pend_addr_o,
   output logic [COST_W-1:0] pend_cost_o
);

   generate
      if (PEND_EN) begin : g_slot
         logic              v_q;
         logic [ADDR_W-1:0] addr_q;
         logic [COST_W-1:0] cost_q;
         logic              cap;

         // Capture when the sequencer is busy and cannot take the request,
         // or when the slot is being drained this very cycle.
         assign cap = req_i && (load_i ? v_q : !v_q);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               v_q    <= 1'b0;
               addr_q <= '0;
               cost_q <= '0;
            end else begin
               if (cap) begin
                  addr_q <= req_addr_i;
                  cost_q <= req_cost_i;
               end
               if (load_i)
                  v_q <= v_q && req_i;
               else if (req_i)
                  v_q <= 1'b1;
            end
         end

         assign pend_v_o    = v_q;
         assign pend_addr_o = addr_q;
         assign pend_cost_o = cost_q;

         assert_pend_hold_R10 : assert property (@(posedge clk) disable iff (!rst_n)
            (v_q && !load_i) |=> (v_q && $stable(addr_q) && $stable(cost_q)));
      end else begin : g_none
         assign pend_v_o    = 1'b0;
         assign pend_addr_o = '0;
         assign pend_cost_o = '0;
      end
   endgenerate

endmodule

// File: rtl/sfs_sequencer.sv
module sfs_sequencer #(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int COST_W   = 3,
   parameter int COST_MAX = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [COST_W-1:0] req_cost_i,
   input  logic              pend_v_i,
   input  logic [ADDR_W-1:0] pend_addr_i,
   input  logic [COST_W-1:0] pend_cost_i,
   input  logic [ADDR_W-1:0] cpu_pc_i,
   input  logic [ADDR_W-1:0] cpu_addr_i,
   input  logic [DATA_W-1:0] bus_rdata_i,
   output logic              load_o,
   output logic              halt_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [DATA_W-1:0] data_o,
   output logic              valid_o
);

   localparam logic [COST_W-1:0] ONE = COST_W'(1);

   logic [COST_W-1:0] left_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              valid_q;
   logic              final_cyc;

   assign final_cyc = (left_q == ONE);
   assign load_o    = (left_q <= ONE);
   assign halt_o    = (left_q != '0);

   always_comb begin
      if (!halt_o)
         bus_addr_o = cpu_addr_i;
      else if (final_cyc)
         bus_addr_o = addr_q;
      else
         bus_addr_o = cpu_pc_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q  <= '0;
         addr_q  <= '0;
         data_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= final_cyc;
         if (final_cyc)
            data_q <= bus_rdata_i;
         if (load_o) begin
            if (pend_v_i) begin
               left_q <= pend_cost_i;
               addr_q <= pend_addr_i;
            end else if (req_i) begin
               left_q <= req_cost_i;
               addr_q <= req_addr_i;
            end else begin
               left_q <= '0;
            end
         end else begin
            left_q <= left_q - ONE;
         end
      end
   end

   assign data_o  = data_q;
   assign valid_o = valid_q;

   assert_cost_range_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (load_o && (pend_v_i || req_i)) |=> (left_q != '0 && int'(left_q) <= COST_MAX));

   assert_stay_halted_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (halt_o && !final_cyc) |=> halt_o);

   assert_valid_after_halt_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(halt_o));

endmodule

// File: rtl/sample_fetch_stall.sv
module sample_fetch_stall #(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int LEFT_W     = 9,
   parameter int COST_MAX   = 7,
   parameter int COST_READ  = 4,
   parameter int COST_WRITE = 3,
   parameter int COST_XFER  = 2,
   parameter int COST_THIRD = 1,
   parameter int COST_LAST  = 3,
   parameter bit PEND_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_req_i,
   input  logic [ADDR_W-1:0] smp_addr_i,
   input  logic              cpu_rd_i,
   input  logic              trig_wr_i,
   input  logic              spr_busy_i,
   input  logic [LEFT_W-1:0] spr_left_i,
   input  logic [ADDR_W-1:0] cpu_pc_i,
   input  logic [ADDR_W-1:0] cpu_addr_i,
   input  logic [DATA_W-1:0] bus_rdata_i,
   output logic              halt_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [DATA_W-1:0] smp_data_o,
   output logic              smp_valid_o
);

   localparam int COST_W = $clog2(COST_MAX + 1);

   if (ADDR_W < 2 || DATA_W < 1) begin : g_bad_width
      $error("sample_fetch_stall: bus widths too small");
   end
   if (LEFT_W < 2) begin : g_bad_left
      $error("sample_fetch_stall: LEFT_W must reach value 3");
   end
   if (COST_READ < 1 || COST_WRITE < 1 || COST_XFER < 1 ||
       COST_THIRD < 1 || COST_LAST < 1) begin : g_bad_cost_lo
      $error("sample_fetch_stall: every stall cost must be at least 1");
   end
   if (COST_READ > COST_MAX || COST_WRITE > COST_MAX || COST_XFER > COST_MAX ||
       COST_THIRD > COST_MAX || COST_LAST > COST_MAX) begin : g_bad_cost_hi
      $error("sample_fetch_stall: a stall cost exceeds COST_MAX");
   end

   logic [COST_W-1:0] cost_now;
   logic              load;
   logic              pend_v;
   logic [ADDR_W-1:0] pend_addr;
   logic [COST_W-1:0] pend_cost;

   sfs_cost_sel #(
      .LEFT_W(LEFT_W), .COST_W(COST_W),
      .COST_READ(COST_READ), .COST_WRITE(COST_WRITE), .COST_XFER(COST_XFER),
      .COST_THIRD(COST_THIRD), .COST_LAST(COST_LAST)
   ) u_cost (
      .cpu_rd_i   (cpu_rd_i),
      .trig_wr_i  (trig_wr_i),
      .spr_busy_i (spr_busy_i),
      .spr_left_i (spr_left_i),
      .cost_o     (cost_now)
   );

   sfs_pending #(
      .ADDR_W(ADDR_W), .COST_W(COST_W), .PEND_EN(PEND_EN)
   ) u_pend (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (smp_req_i),
      .req_addr_i  (smp_addr_i),
      .req_cost_i  (cost_now),
      .load_i      (load),
      .pend_v_o    (pend_v),
      .pend_addr_o (pend_addr),
      .pend_cost_o (pend_cost)
   );

   sfs_sequencer #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COST_W(COST_W), .COST_MAX(COST_MAX)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (smp_req_i),
      .req_addr_i  (smp_addr_i),
      .req_cost_i  (cost_now),
      .pend_v_i    (pend_v),
      .pend_addr_i (pend_addr),
      .pend_cost_i (pend_cost),
      .cpu_pc_i    (cpu_pc_i),
      .cpu_addr_i  (cpu_addr_i),
      .bus_rdata_i (bus_rdata_i),
      .load_o      (load),
      .halt_o      (halt_o),
      .bus_addr_o  (bus_addr_o),
      .data_o      (smp_data_o),
      .valid_o     (smp_valid_o)
   );

   assert_fell_valid_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(halt_o) |-> smp_valid_o);

   assert_idle_start_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (!halt_o && smp_req_i) |=> halt_o);

endmodule

// File: tb/sample_fetch_stall_bench.sv
module sample_fetch_stall_bench;

   localparam int AW = 16;
   localparam int DW = 8;
   localparam int LW = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          cpu_rd = 1'b1;
   logic          trig = 1'b0;
   logic          busy = 1'b0;
   logic [LW-1:0] left = '0;
   logic [AW-1:0] pc = 16'hC123;
   logic [AW-1:0] cpu_addr = 16'h8F00;
   logic [DW-1:0] rdata;
   logic          halt;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] sdata;
   logic          svalid;

   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;

   function automatic logic [DW-1:0] mem(input logic [AW-1:0] a);
      return a[7:0] ^ a[15:8] ^ 8'hA5;
   endfunction

   assign rdata = mem(bus_addr);

   sample_fetch_stall u_sample_fetch_stall (
      .clk(clk), .rst_n(rst_n), .smp_req_i(req), .smp_addr_i(req_addr),
      .cpu_rd_i(cpu_rd), .trig_wr_i(trig), .spr_busy_i(busy), .spr_left_i(left),
      .cpu_pc_i(pc), .cpu_addr_i(cpu_addr), .bus_rdata_i(rdata),
      .halt_o(halt), .bus_addr_o(bus_addr), .smp_data_o(sdata), .smp_valid_o(svalid)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic set_bus(input logic rd, input logic tw, input logic bz, input int lf);
      cpu_rd = rd; trig = tw; busy = bz; left = LW'(lf);
   endtask

   // One isolated fetch: returns halt length, checks addresses and data.
   task automatic run_fetch(input logic rd, input logic tw, input logic bz, input int lf,
                            input logic [AW-1:0] a, input int exp, input string tag);
      int n = 0;
      int nvalid = 0;
      @(negedge clk);
      set_bus(rd, tw, bz, lf);
      req = 1'b1; req_addr = a;
      @(negedge clk);
      req = 1'b0; set_bus(1'b1, 1'b0, 1'b0, 0);
      while (halt && n < 20) begin
         n++;
         if (n == exp)
            check(bus_addr == a, {tag, " R8 final addr"}, bus_addr, a);
         else
            check(bus_addr == pc, {tag, " R8 pc addr"}, bus_addr, pc);
         if (svalid) nvalid++;
         @(negedge clk);
      end
      check(n == exp, {tag, " stall length"}, n, exp);
      check(svalid == 1'b1 && nvalid == 0, {tag, " R9 valid after"}, svalid, 1);
      check(sdata == mem(a), {tag, " R9 data"}, sdata, mem(a));
      check(bus_addr == cpu_addr, {tag, " R12 addr released"}, bus_addr, cpu_addr);
      @(negedge clk);
      check(svalid == 1'b0, {tag, " R9 single pulse"}, svalid, 0);
   endtask

   task automatic test_reset();
      check(!halt, "R1 halt low", halt, 0);
      check(!svalid, "R1 valid low", svalid, 0);
      check(bus_addr == cpu_addr, "R1 addr passthrough", bus_addr, cpu_addr);
   endtask

   task automatic test_costs();
      run_fetch(1'b1, 1'b0, 1'b0, 0,   16'h1234, 4, "R2 read");
      run_fetch(1'b0, 1'b0, 1'b0, 0,   16'h2345, 3, "R3 write");
      run_fetch(1'b0, 1'b1, 1'b0, 0,   16'h3456, 2, "R4 trigger write");
      run_fetch(1'b1, 1'b1, 1'b0, 0,   16'h3457, 2, "R4 trigger read");
      run_fetch(1'b1, 1'b0, 1'b1, 200, 16'h4567, 2, "R5 mid transfer");
      run_fetch(1'b0, 1'b0, 1'b1, 2,   16'h4568, 2, "R5 second-to-last");
      run_fetch(1'b1, 1'b0, 1'b1, 3,   16'h5678, 1, "R6 third-to-last");
      run_fetch(1'b1, 1'b0, 1'b1, 1,   16'h6789, 3, "R7 last");
      run_fetch(1'b0, 1'b0, 1'b1, 1,   16'h678A, 3, "R7 last on write");
   endtask

   // Second request mid-fetch; optional third request while slot is full.
   task automatic test_pending(input bit third, input string tag);
      logic [AW-1:0] a1 = 16'h1111;
      logic [AW-1:0] a2 = 16'h2468;
      logic [AW-1:0] a3 = 16'h7777;
      int n = 0;
      int nvalid = 0;
      logic [DW-1:0] first_data = '0;
      @(negedge clk);
      set_bus(1'b1, 1'b0, 1'b0, 0);
      req = 1'b1; req_addr = a1;
      @(negedge clk);
      req = 1'b0;
      while (halt && n < 30) begin
         n++;
         if (n == 4 || n == 7)
            check(bus_addr == (n == 4 ? a1 : a2), {tag, " R10 final addr"},
                  bus_addr, (n == 4 ? a1 : a2));
         if (svalid) begin nvalid++; first_data = sdata; end
         req = 1'b0; set_bus(1'b1, 1'b0, 1'b0, 0);
         if (n == 2) begin req = 1'b1; req_addr = a2; set_bus(1'b0, 1'b0, 1'b0, 0); end
         if (n == 3 && third) begin req = 1'b1; req_addr = a3; end
         @(negedge clk);
      end
      req = 1'b0;
      check(n == 7, {tag, " R10 back-to-back halt"}, n, 7);
      check(nvalid == 1 && first_data == mem(a1), {tag, " R10 first data"}, first_data, mem(a1));
      check(svalid && sdata == mem(a2), {tag, " R10 second data"}, sdata, mem(a2));
      @(negedge clk);
      check(!halt && !svalid, {tag, " R11 nothing extra"}, halt, 0);
      repeat (6) begin
         @(negedge clk);
         check(!halt, {tag, " R11 no late fetch"}, halt, 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      test_costs();
      test_pending(1'b0, "R10 queued");
      test_pending(1'b1, "R11 dropped");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule